// File: doc/BRIEF.md
# UART Receive Idle and Break Supervisor

This block runs alongside a UART receiver and watches what the receiver reports. The receiver gives it a pulse for each data character it accepts, pulses for parity, framing and noise errors, and the sampled receive line together with a one-cycle strobe per bit time. The block does not deserialize characters itself.

The supervisor has three jobs.

- **Idle timeout.** After each accepted character it counts whole idle character times on the line. When a programmed number of them passes before the next character arrives, it reports a frame boundary. It does this with a one-cycle interrupt pulse and a sticky status bit.
- **Error counting.** It keeps four 16-bit wrapping counters: parity errors, framing errors, noise errors and break conditions. Software can load each counter.
- **Break length.** It measures how long the most recent break lasted. The length is given in bits but counts only whole character times.

The character time is computed from the configured format. It is one start bit, plus five to nine data bits, plus an optional parity bit, plus one or two stop bits.

Top module: `uart_rx_supervisor`

## Requirements
- R1: The character length L in bit times is 1 + D + P + S. D is `cfg_data_bits` clamped to the range 5..9. P is 1 when `cfg_parity_en` is set and 0 otherwise. S is 2 when `cfg_two_stop` is set and 1 otherwise. So 8 data bits with no parity and one stop bit give L = 10.
- R2: A `chr_valid` pulse loads the idle down-counter with `cfg_max_idle` and arms the timer. Each time L high-line bit ticks accumulate, one idle character time has passed. A low-line tick restarts the character time in progress. When the `cfg_max_idle`-th idle character time completes, a timeout occurs on that tick.
- R3: When `cfg_max_idle` is 0 at the time of a `chr_valid`, that character does not arm the timer, and no timeout follows from it.
- R4: A timeout disarms the timer. Only the next `chr_valid` arms it again, so there is at most one timeout per idle period.
- R5: A timeout drives `irq_pulse` high for exactly one cycle: the cycle after the clock edge that sampled the completing tick. In the same cycle it sets `irq_status`. A 1 on `irq_clr` clears `irq_status`, but if a timeout happens in the same cycle, setting wins.
- R6: `cnt_parity`, `cnt_frame` and `cnt_noise` each add 1, modulo 2^16, in the cycle after their error input is sampled high.
- R7: A 1 on `ld_en` writes `ld_val` into the counter chosen by `ld_sel` (0 parity, 1 framing, 2 noise, 3 break). For that counter, the load takes precedence over an increment in the same cycle.
- R8: A break begins when L consecutive bit ticks sample the line low. `cnt_break` rises by exactly 1 per break, however long the line stays low. A tick that samples the line high ends the break.
- R9: `brk_len` equals L times the number of complete character times in the current low run. It updates during the break and then holds. It is first overwritten with L when the next break begins. For example, with L = 7, a 20-tick low run gives 14 and the 21st tick gives 21.
- R10: After reset, all counters, `brk_len`, `irq_pulse` and `irq_status` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| rx_line | input | 1 | Sampled receive line level |
| chr_valid | input | 1 | Data character accepted by the receiver |
| err_parity | input | 1 | Parity error event |
| err_frame | input | 1 | Framing error event |
| err_noise | input | 1 | Noise error event |
| cfg_data_bits | input | 4 | Data bits per character (clamped 5..9) |
| cfg_parity_en | input | 1 | Parity bit present |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_max_idle | input | 16 | Idle character times before timeout, 0 disables |
| ld_en | input | 1 | Counter load strobe |
| ld_sel | input | 2 | Counter to load |
| ld_val | input | 16 | Value to load |
| irq_clr | input | 1 | Write-1 clear of the status bit |
| irq_pulse | output | 1 | One-cycle idle-timeout interrupt |
| irq_status | output | 1 | Sticky idle-timeout status |
| cnt_parity | output | 16 | Parity error count |
| cnt_frame | output | 16 | Framing error count |
| cnt_noise | output | 16 | Noise error count |
| cnt_break | output | 16 | Break condition count |
| brk_len | output | 16 | Length of the last break in bits |

## Verification
The bench aims at these corner cases:

- **Partial idle character.** A low tick in the middle of an idle character must restart that character time. A design that forgets this raises the frame interrupt early.
- **Extra idle time.** Idle time that goes on after a timeout must not cause a second interrupt. A timer that re-arms itself would raise one.
- **Long breaks.** A break several characters long must bump the break counter only once. Its length must read 14 after 20 low bits and 21 after 21 low bits. A design that counts per character, or that reports raw bit counts, differs there.
- **Counter edges.** Counters are checked at the 0xFFFF wrap and for a load that coincides with an increment. A disabled idle value of zero is checked for silence.

// File: rtl/uart_sup_pkg.sv
package uart_sup_pkg;

  localparam int LEN_W = 4;

  typedef enum logic [1:0] {
    SEL_PARITY = 2'd0,
    SEL_FRAME  = 2'd1,
    SEL_NOISE  = 2'd2,
    SEL_BREAK  = 2'd3
  } cnt_sel_e;

  // Character time in bit periods from the configured frame format.
  function automatic logic [LEN_W-1:0] char_bits(input logic [3:0] data_bits,
                                                 input logic       par_en,
                                                 input logic       two_stop);
    logic [LEN_W-1:0] d;
    if (data_bits < 4'd5)      d = 4'd5;
    else if (data_bits > 4'd9) d = 4'd9;
    else                       d = data_bits;
    return 4'd1 + d + {3'b000, par_en} + (two_stop ? 4'd2 : 4'd1);
  endfunction

  // Next value of a modulo counter.
  function automatic logic [15:0] wrap_inc(input logic [15:0] v);
    return v + 16'd1;
  endfunction

endpackage

// File: rtl/sup_idle_timer.sv
module sup_idle_timer #(
  parameter int IDLE_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              rx_line,
  input  logic              chr_valid,
  input  logic [IDLE_W-1:0] max_idle,
  input  logic [LEN_W-1:0]  char_len,
  output logic              timeout_evt,
  output logic              armed
);

  logic [IDLE_W-1:0] left_q;
  logic [LEN_W-1:0]  bit_q;
  logic              char_done;
  logic              last_char;

  assign char_done   = armed && !chr_valid && bit_tick && rx_line &&
                       (bit_q == char_len - LEN_W'(1));
  assign last_char   = (left_q == IDLE_W'(1));
  assign timeout_evt = char_done && last_char;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      left_q <= '0;
      bit_q  <= '0;
    end else if (chr_valid) begin
      armed  <= (max_idle != '0);
      left_q <= max_idle;
      bit_q  <= '0;
    end else if (armed && bit_tick) begin
      if (!rx_line) begin
        bit_q <= '0;
      end else if (char_done) begin
        bit_q <= '0;
        if (last_char) armed  <= 1'b0;
        else           left_q <= left_q - IDLE_W'(1);
      end else begin
        bit_q <= bit_q + LEN_W'(1);
      end
    end
  end

endmodule

// File: rtl/sup_break_meter.sv
module sup_break_meter #(
  parameter int LEN_W = 4,
  parameter int BRK_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             rx_line,
  input  logic [LEN_W-1:0] char_len,
  output logic             brk_start,
  output logic [BRK_W-1:0] brk_len
);

  logic [LEN_W-1:0] phase_q;
  logic             in_brk_q;
  logic             full_char;

  assign full_char = bit_tick && !rx_line && (phase_q == char_len - LEN_W'(1));
  assign brk_start = full_char && !in_brk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= '0;
      in_brk_q <= 1'b0;
      brk_len  <= '0;
    end else if (bit_tick) begin
      if (rx_line) begin
        phase_q  <= '0;
        in_brk_q <= 1'b0;
      end else if (full_char) begin
        phase_q  <= '0;
        in_brk_q <= 1'b1;
        brk_len  <= in_brk_q ? brk_len + BRK_W'(char_len) : BRK_W'(char_len);
      end else begin
        phase_q <= phase_q + LEN_W'(1);
      end
    end
  end

endmodule

// File: rtl/sup_event_counter.sv
module sup_event_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (ld)  count <= ld_val;
    else if (inc) count <= count + W'(1);
  end

endmodule

// File: rtl/uart_rx_supervisor.sv
module uart_rx_supervisor
  import uart_sup_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int IDLE_W = 16,
  parameter int BRK_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              rx_line,
  input  logic              chr_valid,
  input  logic              err_parity,
  input  logic              err_frame,
  input  logic              err_noise,
  input  logic [3:0]        cfg_data_bits,
  input  logic              cfg_parity_en,
  input  logic              cfg_two_stop,
  input  logic [IDLE_W-1:0] cfg_max_idle,
  input  logic              ld_en,
  input  logic [1:0]        ld_sel,
  input  logic [CNT_W-1:0]  ld_val,
  input  logic              irq_clr,
  output logic              irq_pulse,
  output logic              irq_status,
  output logic [CNT_W-1:0]  cnt_parity,
  output logic [CNT_W-1:0]  cnt_frame,
  output logic [CNT_W-1:0]  cnt_noise,
  output logic [CNT_W-1:0]  cnt_break,
  output logic [BRK_W-1:0]  brk_len
);

  localparam int N_CNT = 4;

  logic [LEN_W-1:0] char_len;
  logic             timeout_evt;
  logic             idle_armed;
  logic             brk_start;
  logic [N_CNT-1:0] inc_vec;
  logic [N_CNT-1:0] ld_vec;
  logic [CNT_W-1:0] cnt_arr [N_CNT];

  assign char_len = char_bits(cfg_data_bits, cfg_parity_en, cfg_two_stop);

  sup_idle_timer #(.IDLE_W(IDLE_W), .LEN_W(LEN_W)) u_idle (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_line(rx_line),
    .chr_valid(chr_valid), .max_idle(cfg_max_idle), .char_len(char_len),
    .timeout_evt(timeout_evt), .armed(idle_armed)
  );

  sup_break_meter #(.LEN_W(LEN_W), .BRK_W(BRK_W)) u_brk (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_line(rx_line),
    .char_len(char_len), .brk_start(brk_start), .brk_len(brk_len)
  );

  assign inc_vec[SEL_PARITY] = err_parity;
  assign inc_vec[SEL_FRAME]  = err_frame;
  assign inc_vec[SEL_NOISE]  = err_noise;
  assign inc_vec[SEL_BREAK]  = brk_start;

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    assign ld_vec[i] = ld_en && (ld_sel == 2'(i));
    sup_event_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc_vec[i]), .ld(ld_vec[i]),
      .ld_val(ld_val), .count(cnt_arr[i])
    );
  end

  assign cnt_parity = cnt_arr[SEL_PARITY];
  assign cnt_frame  = cnt_arr[SEL_FRAME];
  assign cnt_noise  = cnt_arr[SEL_NOISE];
  assign cnt_break  = cnt_arr[SEL_BREAK];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pulse  <= 1'b0;
      irq_status <= 1'b0;
    end else begin
      irq_pulse <= timeout_evt;
      if (timeout_evt)  irq_status <= 1'b1;
      else if (irq_clr) irq_status <= 1'b0;
    end
  end

endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
  parameter int CNT_W = 16,
  parameter int BRK_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic             rx_line,
  input logic             chr_valid,
  input logic             err_parity,
  input logic             ld_en,
  input logic [1:0]       ld_sel,
  input logic             irq_clr,
  input logic             irq_pulse,
  input logic             irq_status,
  input logic             timeout_evt,
  input logic             idle_armed,
  input logic             brk_start,
  input logic [CNT_W-1:0] cnt_parity,
  input logic [CNT_W-1:0] cnt_break,
  input logic [BRK_W-1:0] brk_len
);

  AST_TIMEOUT_ON_HIGH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |-> (bit_tick && rx_line && !chr_valid)); // R2
  AST_REARM_BY_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_armed) |-> $past(chr_valid)); // R4
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_status); // R5
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !timeout_evt) |=> !irq_status); // R5
  AST_PARITY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_parity && !(ld_en && ld_sel == 2'd0)) |=>
      (cnt_parity == $past(cnt_parity) + CNT_W'(1))); // R6
  AST_BREAK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!brk_start && !(ld_en && ld_sel == 2'd3)) |=> $stable(cnt_break)); // R8
  AST_BRK_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_tick && !rx_line) |=> $stable(brk_len)); // R9

endmodule

bind uart_rx_supervisor sup_checker #(.CNT_W(CNT_W), .BRK_W(BRK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_line(rx_line),
  .chr_valid(chr_valid), .err_parity(err_parity), .ld_en(ld_en), .ld_sel(ld_sel),
  .irq_clr(irq_clr), .irq_pulse(irq_pulse), .irq_status(irq_status),
  .timeout_evt(timeout_evt), .idle_armed(idle_armed), .brk_start(brk_start),
  .cnt_parity(cnt_parity), .cnt_break(cnt_break), .brk_len(brk_len)
);

// File: tb/sim_uart_rx_supervisor.sv
`timescale 1ns/1ps
module sim_uart_rx_supervisor;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 0, rx_line = 1, chr_valid = 0;
  logic err_parity = 0, err_frame = 0, err_noise = 0;
  logic [3:0] cfg_data_bits = 4'd8;
  logic cfg_parity_en = 0, cfg_two_stop = 0;
  logic [15:0] cfg_max_idle = 16'd2;
  logic ld_en = 0;
  logic [1:0] ld_sel = 0;
  logic [15:0] ld_val = 0;
  logic irq_clr = 0;
  logic irq_pulse, irq_status;
  logic [15:0] cnt_parity, cnt_frame, cnt_noise, cnt_break, brk_len;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_rx_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_line(rx_line),
    .chr_valid(chr_valid), .err_parity(err_parity), .err_frame(err_frame),
    .err_noise(err_noise), .cfg_data_bits(cfg_data_bits),
    .cfg_parity_en(cfg_parity_en), .cfg_two_stop(cfg_two_stop),
    .cfg_max_idle(cfg_max_idle), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_val(ld_val), .irq_clr(irq_clr), .irq_pulse(irq_pulse),
    .irq_status(irq_status), .cnt_parity(cnt_parity), .cnt_frame(cnt_frame),
    .cnt_noise(cnt_noise), .cnt_break(cnt_break), .brk_len(brk_len)
  );

  // Behavioural reference model
  int m_armed, m_left, m_bits, m_irqp, m_irqs, m_phase, m_inbrk, m_blen;
  int m_cnt [4];

  function automatic int model_len();
    int d;
    d = cfg_data_bits;
    if (d < 5) d = 5;
    if (d > 9) d = 9;
    return 1 + d + (cfg_parity_en ? 1 : 0) + (cfg_two_stop ? 2 : 1);
  endfunction

  always @(posedge clk) begin
    int len, evt, bs;
    if (!rst_n) begin
      m_armed = 0; m_left = 0; m_bits = 0; m_irqp = 0; m_irqs = 0;
      m_phase = 0; m_inbrk = 0; m_blen = 0;
      for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    end else begin
      len = model_len();
      evt = 0;
      bs = 0;
      if (chr_valid) begin
        m_armed = (cfg_max_idle != 0); m_left = cfg_max_idle; m_bits = 0;
      end else if (m_armed != 0 && bit_tick) begin
        if (!rx_line) m_bits = 0;
        else if (m_bits + 1 == len) begin
          m_bits = 0;
          if (m_left == 1) begin evt = 1; m_armed = 0; end
          else m_left = m_left - 1;
        end else m_bits = m_bits + 1;
      end
      m_irqp = evt;
      if (evt != 0) m_irqs = 1;
      else if (irq_clr) m_irqs = 0;
      if (bit_tick) begin
        if (rx_line) begin m_phase = 0; m_inbrk = 0; end
        else if (m_phase + 1 == len) begin
          m_phase = 0;
          if (m_inbrk == 0) begin bs = 1; m_inbrk = 1; m_blen = len; end
          else m_blen = (m_blen + len) % 65536;
        end else m_phase = m_phase + 1;
      end
      for (int i = 0; i < 4; i++) begin
        int inc;
        inc = (i == 0) ? int'(err_parity) : (i == 1) ? int'(err_frame) :
              (i == 2) ? int'(err_noise) : bs;
        if (ld_en && ld_sel == 2'(i)) m_cnt[i] = ld_val;
        else if (inc != 0) m_cnt[i] = (m_cnt[i] + 1) % 65536;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5 irq_pulse", int'(irq_pulse), m_irqp);
      check("R5 irq_status", int'(irq_status), m_irqs);
      check("R6 cnt_parity", int'(cnt_parity), m_cnt[0]);
      check("R6 cnt_frame", int'(cnt_frame), m_cnt[1]);
      check("R7 cnt_noise", int'(cnt_noise), m_cnt[2]);
      check("R8 cnt_break", int'(cnt_break), m_cnt[3]);
      check("R9 brk_len", int'(brk_len), m_blen);
    end
  end

  task automatic bits(int n, logic lvl);
    repeat (n) begin
      @(negedge clk); rx_line = lvl; bit_tick = 1;
      @(negedge clk); bit_tick = 0;
      @(negedge clk);
    end
  endtask

  task automatic chr();
    @(negedge clk); chr_valid = 1;
    @(negedge clk); chr_valid = 0;
  endtask

  task automatic clr_irq();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
  endtask

  task automatic load(logic [1:0] s, logic [15:0] v);
    @(negedge clk); ld_en = 1; ld_sel = s; ld_val = v;
    @(negedge clk); ld_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check("R10 irq_status", int'(irq_status), 0);
    check("R10 cnt_break", int'(cnt_break), 0);
    check("R10 brk_len", int'(brk_len), 0);

    // R1 and R2: 8N1 gives L=10, two idle chars -> 20 high ticks
    chr(); bits(19, 1);
    check("R2 no timeout at 19 ticks", int'(irq_status), 0);
    bits(1, 1);
    check("R1 R2 timeout at 20 ticks", int'(irq_status), 1);
    clr_irq();
    check("R5 cleared", int'(irq_status), 0);
    bits(30, 1);
    check("R4 no second timeout", int'(irq_status), 0);

    // R2: low tick restarts partial character time
    cfg_max_idle = 16'd1;
    chr(); bits(9, 1); bits(1, 0); bits(9, 1);
    check("R2 restart after low tick", int'(irq_status), 0);
    bits(1, 1);
    check("R2 timeout after restart", int'(irq_status), 1);
    clr_irq();

    // R3: zero disables
    cfg_max_idle = 16'd0;
    chr(); bits(40, 1);
    check("R3 disabled", int'(irq_status), 0);

    // R1 with parity and two stops: L = 1+8+1+2 = 12
    cfg_max_idle = 16'd1; cfg_parity_en = 1; cfg_two_stop = 1;
    chr(); bits(11, 1);
    check("R1 L=12 before", int'(irq_status), 0);
    bits(1, 1);
    check("R1 L=12 at", int'(irq_status), 1);
    clr_irq();
    cfg_parity_en = 0; cfg_two_stop = 0;

    // R8 R9: L=7 with 5 data bits
    cfg_data_bits = 4'd5;
    bits(20, 0);
    check("R9 20 low -> 14", int'(brk_len), 14);
    check("R8 one break", int'(cnt_break), 1);
    bits(1, 0);
    check("R9 21 low -> 21", int'(brk_len), 21);
    check("R8 still one break", int'(cnt_break), 1);
    bits(1, 1); bits(3, 0); bits(1, 1);
    check("R9 hold after short low", int'(brk_len), 21);
    bits(7, 0);
    check("R9 new break -> 7", int'(brk_len), 7);
    check("R8 second break", int'(cnt_break), 2);
    bits(1, 1);
    // R1 clamp: data 15 -> 9, L = 11
    cfg_data_bits = 4'd15;
    bits(11, 0);
    check("R1 clamp L=11", int'(brk_len), 11);
    bits(1, 1);

    // R6 R7 counters
    repeat (3) begin
      @(negedge clk); err_parity = 1; @(negedge clk); err_parity = 0;
    end
    check("R6 parity count 3", int'(cnt_parity), 3);
    load(2'd2, 16'hFFFF);
    @(negedge clk); err_noise = 1; @(negedge clk); err_noise = 0;
    check("R6 wrap to 0", int'(cnt_noise), 0);
    @(negedge clk); ld_en = 1; ld_sel = 2'd1; ld_val = 16'd500; err_frame = 1;
    @(negedge clk); ld_en = 0; err_frame = 0;
    check("R7 load beats increment", int'(cnt_frame), 500);
    load(2'd3, 16'd77);
    check("R7 load break counter", int'(cnt_break), 77);

    // Random stimulus compared every cycle with the model
    cfg_data_bits = 4'd6; cfg_max_idle = 16'd1;
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      bit_tick   = ($urandom_range(0, 2) == 0);
      rx_line    = ($urandom_range(0, 9) != 0) ^ (k % 400 > 330);
      chr_valid  = ($urandom_range(0, 60) == 0);
      err_parity = ($urandom_range(0, 20) == 0);
      err_frame  = ($urandom_range(0, 20) == 0);
      err_noise  = ($urandom_range(0, 20) == 0);
      irq_clr    = ($urandom_range(0, 30) == 0);
      ld_en      = ($urandom_range(0, 50) == 0);
      ld_sel     = 2'($urandom_range(0, 3));
      ld_val     = 16'($urandom);
    end
    @(negedge clk);
    bit_tick = 0; chr_valid = 0; err_parity = 0; err_frame = 0;
    err_noise = 0; irq_clr = 0; ld_en = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule